// File: doc/BRIEF.md
# Character-Cell Text Overlay Renderer

This block draws a grid of text over a video raster. A host fills a small display memory with cell words through a write port. Each word is either a character, which names one of 512 glyphs and may carry attributes for that one cell, or a serial attribute, which changes colours, size and outlining for the rest of the row. The block counts incoming frame and line pulses to find the text row and the scan line inside it. It then walks the row's cells and sends out one colour index per clock, with a flag that marks the text span.

Glyphs are 10 by 10 dots and come from a built-in table that is computed, not loaded. A cell can be drawn at 1x to 4x. The same factor widens each dot and repeats each glyph line, so a text row is 40 scan lines tall. A controller with three states sequences each scan line. In **IDLE** it waits. A line pulse on a line inside the window moves it to **PRIME**, where the first cell is latched. It then always moves to **DRAW**, where dots stream out and each following cell is latched during the last dot of the one before. After the last dot of the last cell it returns to IDLE. A frame pulse forces IDLE from any state, and a line pulse from any state restarts the walk through PRIME, or goes to IDLE when the line is below the window.

Top module: `osd_renderer`

## Requirements
- R1: After reset, `osd_active` is low and `pix_color` is 0.
- R2: If `line_start` is sampled high at edge E0 on a line inside the window, dot 0 of the row is on the outputs after edge E0+2. The row's dots follow one per clock with no gap: each cell is 10 times its scale factor wide, and there are COLS cells. On the clock after the last dot, `osd_active` is low again.
- R3: A cell word has bit 12 at 0 for a character, with code = bits 8:0. Dot (line r, column c) of a glyph is lit when 1 ≤ r ≤ 8, 1 ≤ c ≤ 8 and (code + r·c) mod 5 < 2. Column 0 is the leftmost dot. A lit dot shows the foreground colour and an unlit dot the background colour. At the start of every scan line the serial state is foreground 7, background 0, size 1x, fringe off.
- R4: A word with bit 12 at 1 is a serial attribute: foreground = bits 3:0, background = bits 7:4, size code = bits 9:8, fringe enable = bit 10. It updates the serial state for itself and for the following cells of the same scan line. The cell draws only its new background colour, at the width of its new size.
- R5: Size code s gives a factor k = s+1. Each glyph column spans k dots and glyph line g covers row lines g·k to g·k+k−1. Row lines at or beyond 10·k show the cell's background.
- R6: For a character, bit 9 inverts bit 3 of the foreground index and bit 10 inverts bit 3 of the background index. Both apply to that cell only.
- R7: A character with bit 11 set draws its whole glyph line 9 in its foreground colour.
- R8: With fringe on, an unlit dot of a character that has a lit dot of the same glyph directly left, right, above or below it shows colour FRINGE_COLOR. Underline takes precedence over fringe.
- R9: `frame_start` makes the next `line_start` scan line 0. Scan lines at or beyond ROWS·40 leave `osd_active` low and `pix_color` at 0. Whenever `osd_active` is low, `pix_color` is 0.
- R10: A write puts `wr_data` at cell address row·COLS + column, and it is seen by every scan line started after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-clock pulse; restarts scan line counting |
| line_start | input | 1 | One-clock pulse at the start of each scan line |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | ADDR_W | Cell address, row·COLS + column |
| wr_data | input | 13 | Cell word |
| osd_active | output | 1 | High while a text dot is being output |
| pix_color | output | 4 | Colour index of the current dot |

## Verification
Some properties are checked on every clock. The colour is zero whenever the flag is low. PRIME always gives way to DRAW. The dot and replication counters stay inside the current cell and its scale. A serial cell outputs exactly its background colour. Host writes stay inside the memory. Only the bench scenarios can show the rest: the glyph shapes, the exact dot timing after a line pulse, serial state that persists along a line and resets on the next, per-cell colour flips, underline, fringe placement, scaling in both directions, the window limit and frame restart. The bench sweeps every dot of every scan line of a two-row, four-column screen and compares each one with a model computed from the requirements.

// File: rtl/osd_pkg.sv
package osd_pkg;
    localparam int COLOR_W    = 4;
    localparam int WORD_W     = 13;
    localparam int CODE_W     = 9;
    localparam int GLYPH_W    = 10;
    localparam int GLYPH_H    = 10;
    localparam int MAX_SCALE  = 4;
    localparam int KIND_BIT   = 12;
    localparam int ULINE_BIT  = 11;
    localparam int ALT_BG_BIT = 10;
    localparam int ALT_FG_BIT = 9;
    localparam int FRINGE_BIT = 10;
    localparam int SIZE_LSB   = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIME,
        ST_DRAW
    } osd_state_e;

    typedef struct packed {
        logic [COLOR_W-1:0] fg;
        logic [COLOR_W-1:0] bg;
        logic [1:0]         size;
        logic               fringe;
    } ser_attr_t;

    localparam ser_attr_t SER_DEFAULT = '{fg: 4'd7, bg: 4'd0, size: 2'd0, fringe: 1'b0};
endpackage

// File: rtl/osd_cell_mem.sv
module osd_cell_mem #(
    parameter int DEPTH = 2080,
    parameter int AW    = 12,
    parameter int DW    = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    // host writes land inside the screen (R10)
    assert_wr_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/osd_glyph_rom.sv
module osd_glyph_rom
    import osd_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    input  logic [4:0]         line,
    output logic [GLYPH_W-1:0] bits
);
    logic line_inner;
    assign line_inner = (line >= 5'd1) && (line <= 5'd8);

    for (genvar c = 0; c < GLYPH_W; c++) begin : g_col
        if (c == 0 || c == GLYPH_W - 1) begin : g_edge
            assign bits[c] = 1'b0;
        end else begin : g_body
            assign bits[c] = line_inner && (((int'(code) + int'(line) * c) % 5) < 2);
        end
    end
endmodule

// File: rtl/osd_dot_shade.sv
module osd_dot_shade
    import osd_pkg::*;
#(
    parameter logic [COLOR_W-1:0] FRINGE_COLOR = 4'd1
) (
    input  logic                   blank,
    input  logic                   glyph_ok,
    input  logic                   glyph_bottom,
    input  logic                   uline,
    input  logic                   fringe_en,
    input  logic [COLOR_W-1:0]     fg,
    input  logic [COLOR_W-1:0]     bg,
    input  logic [3:0]             dot,
    input  logic [3*GLYPH_W-1:0]   rows,
    output logic [COLOR_W-1:0]     color
);
    logic [GLYPH_W-1:0] row_up, row_mid, row_dn;
    logic [GLYPH_W+1:0] mid_pad;
    logic               lit, near;

    always_comb begin
        row_up  = rows[0 +: GLYPH_W];
        row_mid = rows[GLYPH_W +: GLYPH_W];
        row_dn  = rows[2*GLYPH_W +: GLYPH_W];
        mid_pad = {1'b0, row_mid, 1'b0};
        lit     = mid_pad[dot + 4'd1];
        near    = row_up[dot] | row_dn[dot] | mid_pad[dot] | mid_pad[dot + 4'd2];
        if (blank || !glyph_ok) begin
            color = bg;
        end else if (uline && glyph_bottom) begin
            color = fg;
        end else if (lit) begin
            color = fg;
        end else if (fringe_en && near) begin
            color = FRINGE_COLOR;
        end else begin
            color = bg;
        end
    end
endmodule

// File: rtl/osd_renderer.sv
module osd_renderer
    import osd_pkg::*;
#(
    parameter int ROWS = 26,
    parameter int COLS = 80,
    parameter logic [COLOR_W-1:0] FRINGE_COLOR = 4'd1,
    localparam int CELLS  = ROWS * COLS,
    localparam int ADDR_W = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    output logic               osd_active,
    output logic [COLOR_W-1:0] pix_color
);
    localparam int ROW_LINES = GLYPH_H * MAX_SCALE;
    localparam int LIN_W     = $clog2(ROW_LINES);
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int COL_W     = $clog2(COLS + 1);
    localparam int DOT_W     = $clog2(GLYPH_W);
    localparam int SUB_W     = $clog2(MAX_SCALE);

    osd_state_e          state, state_nx;
    ser_attr_t           ser_q, ser_eff;
    logic [ROW_W-1:0]    v_row, cur_row;
    logic [LIN_W-1:0]    v_lin, cur_lin, gline;
    logic                v_done;
    logic [COL_W-1:0]    col_ptr, col_sel;
    logic [DOT_W-1:0]    dot_cnt;
    logic [SUB_W-1:0]    sub_cnt;
    logic [ADDR_W-1:0]   rd_addr;
    logic [WORD_W-1:0]   word;
    logic                is_ser, last_dot, row_end, load_cell;
    logic [3*GLYPH_W-1:0] rom_flat, cur_rows;
    logic                cur_blank, cur_fringe, cur_ul, cur_gok, cur_gbot;
    logic [1:0]          cur_size;
    logic [COLOR_W-1:0]  cur_fg, cur_bg, shade;

    function automatic logic [LIN_W-1:0] lin_div(input logic [LIN_W-1:0] l, input logic [1:0] s);
        case (s)
            2'd0:    return l;
            2'd1:    return l >> 1;
            2'd2:    return LIN_W'(l / 3);
            default: return l >> 2;
        endcase
    endfunction

    osd_cell_mem #(.DEPTH(CELLS), .AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(word)
    );

    // cell fetch: effective serial state, glyph line, three neighbouring rows
    always_comb begin
        col_sel = (state == ST_PRIME) ? '0 : col_ptr;
        rd_addr = ADDR_W'(int'(cur_row) * COLS + int'(col_sel));
        is_ser  = word[KIND_BIT];
        ser_eff = ser_q;
        if (is_ser) begin
            ser_eff.fg     = word[COLOR_W-1:0];
            ser_eff.bg     = word[2*COLOR_W-1:COLOR_W];
            ser_eff.size   = word[SIZE_LSB +: 2];
            ser_eff.fringe = word[FRINGE_BIT];
        end
        gline = lin_div(cur_lin, ser_eff.size);
    end

    for (genvar k = 0; k < 3; k++) begin : g_rom
        logic [4:0] ln_sel;
        always_comb begin
            int ln;
            ln = int'(gline) + k - 1;
            ln_sel = (ln >= 0 && ln < GLYPH_H) ? 5'(ln) : 5'd31;
        end
        osd_glyph_rom u_rom (
            .code(word[CODE_W-1:0]), .line(ln_sel), .bits(rom_flat[k*GLYPH_W +: GLYPH_W])
        );
    end

    assign last_dot  = (dot_cnt == DOT_W'(GLYPH_W - 1)) && (sub_cnt == cur_size);
    assign row_end   = last_dot && (col_ptr == COL_W'(COLS));
    assign load_cell = (state == ST_PRIME) || (state == ST_DRAW && last_dot && !row_end);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (frame_start) begin
            state_nx = ST_IDLE;
        end else if (line_start) begin
            state_nx = v_done ? ST_IDLE : ST_PRIME;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_PRIME: state_nx = ST_DRAW;
                ST_DRAW:  state_nx = row_end ? ST_IDLE : ST_DRAW;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // raster counters and cell latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_row <= '0; v_lin <= '0; v_done <= 1'b0;
            cur_row <= '0; cur_lin <= '0;
            ser_q <= SER_DEFAULT;
            col_ptr <= '0; dot_cnt <= '0; sub_cnt <= '0;
            cur_blank <= 1'b1; cur_fringe <= 1'b0; cur_ul <= 1'b0;
            cur_gok <= 1'b0; cur_gbot <= 1'b0; cur_size <= 2'd0;
            cur_fg <= '0; cur_bg <= '0; cur_rows <= '0;
        end else begin
            if (frame_start) begin
                v_row <= '0; v_lin <= '0; v_done <= 1'b0;
            end else if (line_start) begin
                cur_row <= v_row;
                cur_lin <= v_lin;
                if (v_lin == LIN_W'(ROW_LINES - 1)) begin
                    v_lin <= '0;
                    if (v_row == ROW_W'(ROWS - 1)) v_done <= 1'b1;
                    else                            v_row  <= v_row + 1'b1;
                end else begin
                    v_lin <= v_lin + 1'b1;
                end
            end
            if (line_start) begin
                ser_q <= SER_DEFAULT;
            end else if (load_cell) begin
                ser_q <= ser_eff;
            end
            if (load_cell) begin
                cur_blank  <= is_ser;
                cur_size   <= ser_eff.size;
                cur_fringe <= ser_eff.fringe;
                cur_fg     <= ser_eff.fg ^ {~is_ser & word[ALT_FG_BIT], {(COLOR_W-1){1'b0}}};
                cur_bg     <= ser_eff.bg ^ {~is_ser & word[ALT_BG_BIT], {(COLOR_W-1){1'b0}}};
                cur_ul     <= ~is_ser & word[ULINE_BIT];
                cur_gok    <= gline < LIN_W'(GLYPH_H);
                cur_gbot   <= gline == LIN_W'(GLYPH_H - 1);
                cur_rows   <= rom_flat;
                dot_cnt    <= '0;
                sub_cnt    <= '0;
                col_ptr    <= (state == ST_PRIME) ? COL_W'(1) : col_ptr + 1'b1;
            end else if (state == ST_DRAW && !row_end) begin
                if (sub_cnt == cur_size) begin
                    sub_cnt <= '0;
                    dot_cnt <= dot_cnt + 1'b1;
                end else begin
                    sub_cnt <= sub_cnt + 1'b1;
                end
            end
        end
    end

    osd_dot_shade #(.FRINGE_COLOR(FRINGE_COLOR)) u_shade (
        .blank(cur_blank), .glyph_ok(cur_gok), .glyph_bottom(cur_gbot), .uline(cur_ul),
        .fringe_en(cur_fringe), .fg(cur_fg), .bg(cur_bg), .dot(dot_cnt), .rows(cur_rows),
        .color(shade)
    );

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osd_active <= 1'b0;
            pix_color  <= '0;
        end else begin
            osd_active <= (state == ST_DRAW);
            pix_color  <= (state == ST_DRAW) ? shade : '0;
        end
    end

    assert_dark_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !osd_active |-> (pix_color == '0));
    assert_prime_then_draw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME && !frame_start && !line_start) |=> (state == ST_DRAW));
    assert_sub_within_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAW) |-> (sub_cnt <= cur_size));
    assert_dot_within_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAW) |-> (dot_cnt < DOT_W'(GLYPH_W)));
    assert_serial_cell_bg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAW && cur_blank) |=> (pix_color == $past(cur_bg)));
endmodule

// File: tb/osd_renderer_test.sv
module osd_renderer_test;
    localparam int ROWS  = 2;
    localparam int COLS  = 4;
    localparam int CELLS = ROWS * COLS;
    localparam int AW    = $clog2(CELLS);
    localparam int RL    = 40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n, frame_start, line_start, wr_en;
    logic [AW-1:0] wr_addr;
    logic [12:0]   wr_data;
    logic          osd_active;
    logic [3:0]    pix_color;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;
    logic [12:0] img [CELLS];
    int exp_col [200];
    int exp_n;

    osd_renderer #(.ROWS(ROWS), .COLS(COLS), .FRINGE_COLOR(4'd1)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .osd_active(osd_active), .pix_color(pix_color)
    );

    function automatic bit g_on(int code, int r, int c);
        if (r < 1 || r > 8 || c < 1 || c > 8) return 1'b0;
        return ((code + r * c) % 5) < 2;
    endfunction

    function automatic logic [12:0] ser(int fg, int bg, int sz, int fr);
        return {1'b1, 1'b0, fr[0], sz[1:0], bg[3:0], fg[3:0]};
    endfunction

    function automatic logic [12:0] chr(int code, int afg, int abg, int ul);
        return {1'b0, ul[0], abg[0], afg[0], code[8:0]};
    endfunction

    task automatic build_line(int ln);
        int row, lin, fg, bg, sz, fr;
        row = ln / RL; lin = ln % RL;
        exp_n = 0;
        fg = 7; bg = 0; sz = 0; fr = 0;
        if (row >= ROWS) return;
        for (int col = 0; col < COLS; col++) begin
            logic [12:0] w;
            int s, g, code, cfg, cbg;
            w = img[row * COLS + col];
            if (w[12]) begin
                fg = int'(w[3:0]); bg = int'(w[7:4]); sz = int'(w[9:8]); fr = int'(w[10]);
                s = sz + 1;
                for (int x = 0; x < 10 * s; x++) begin exp_col[exp_n] = bg; exp_n++; end
            end else begin
                s = sz + 1; g = lin / s; code = int'(w[8:0]);
                cfg = fg ^ (w[9] ? 8 : 0);
                cbg = bg ^ (w[10] ? 8 : 0);
                for (int x = 0; x < 10 * s; x++) begin
                    int c, v;
                    c = x / s;
                    if (g >= 10) v = cbg;
                    else if (w[11] && g == 9) v = cfg;
                    else if (g_on(code, g, c)) v = cfg;
                    else if (fr != 0 && (g_on(code, g - 1, c) || g_on(code, g + 1, c) ||
                                         g_on(code, g, c - 1) || g_on(code, g, c + 1))) v = 1;
                    else v = cbg;
                    exp_col[exp_n] = v; exp_n++;
                end
            end
        end
    endtask

    task automatic check(string req, int act, int expv);
        vectors++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic put_cell(int addr, logic [12:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        img[addr] = w;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic run_line(int ln, string req);
        build_line(ln);
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        for (int j = 1; j <= exp_n + 3; j++) begin
            int expv;
            @(negedge clk);
            if (j >= 2 && (j - 2) < exp_n) expv = 16 + exp_col[j - 2];
            else                           expv = 0;
            check(req, int'(osd_active) * 16 + int'(pix_color), expv);
        end
    endtask

    task automatic run_frame(string req);
        pulse_frame();
        for (int ln = 0; ln < ROWS * RL + 2; ln++) run_line(ln, req);
    endtask

    initial begin
        #(190000 * 20);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_start = 1'b0; line_start = 1'b0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1", int'(osd_active) * 16 + int'(pix_color), 0);
        end

        // R3 plain glyphs in default colours, R2 timing, R9 lines below window
        put_cell(0, chr(0, 0, 0, 0));   put_cell(1, chr(37, 0, 0, 0));
        put_cell(2, chr(129, 0, 0, 0)); put_cell(3, chr(511, 0, 0, 0));
        put_cell(4, chr(2, 0, 0, 0));   put_cell(5, chr(300, 0, 0, 0));
        put_cell(6, chr(77, 0, 0, 0));  put_cell(7, chr(450, 0, 0, 0));
        run_frame("R3 R2 R9");

        // R4 serial persistence and per-line reset, R5 scaling
        put_cell(0, ser(3, 5, 1, 0));   put_cell(1, chr(100, 0, 0, 0));
        put_cell(2, ser(2, 6, 3, 0));   put_cell(3, chr(7, 0, 0, 0));
        put_cell(4, chr(12, 0, 0, 0));  put_cell(5, ser(9, 10, 2, 0));
        put_cell(6, chr(250, 0, 0, 0)); put_cell(7, chr(4, 0, 0, 0));
        run_frame("R4 R5");

        // R6 parallel colour flips, R7 underline, R8 fringe
        put_cell(0, ser(7, 2, 0, 1));   put_cell(1, chr(33, 1, 0, 0));
        put_cell(2, chr(66, 0, 1, 1));  put_cell(3, chr(99, 1, 1, 0));
        put_cell(4, ser(5, 0, 1, 1));   put_cell(5, chr(200, 0, 0, 1));
        put_cell(6, chr(123, 1, 0, 0)); put_cell(7, ser(6, 3, 0, 0));
        run_frame("R6 R7 R8");

        // R10 mid-frame write, R9 frame restart
        pulse_frame();
        run_line(0, "R10");
        run_line(1, "R10");
        put_cell(1, chr(401, 0, 0, 1));
        put_cell(2, ser(12, 4, 3, 1));
        for (int ln = 2; ln < 6; ln++) run_line(ln, "R10");
        pulse_frame();
        for (int ln = 0; ln < 3; ln++) run_line(ln, "R9");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule